// File: doc/BRIEF.md
# Multiload Image Page Loader

This block pulls one program image out of a large backing store and places it into an 8 KB banked RAM. The store holds a number of fixed-size records. Each record is 8448 bytes long: 32 data pages of 256 bytes, then a 256-byte header at record offset 8192. A start pulse gives the wanted load number. The loader walks the records in order until it finds a header that carries that number. It then reads the page count and copies each listed page to the RAM bank and page named by that page's descriptor byte.

While it copies, the loader checks two 8-bit sums. The first covers the header. The second covers each page, and it also folds in the page's descriptor and a per-page partner byte. A bad sum only raises a warning flag, and the copy still runs to the end. Once all pages are placed, three header bytes go out to a small host RAM port for the startup code to pick up. All memory ports are synchronous, and a read returns its data one clock after it is issued.

Top module: `multiload_loader`

## Requirements
- R1: While reset is applied and after it is released, busy_o, done_o, hdr_warn_o, page_warn_o, miss_o, ram_we_o, host_we_o and store_rd_o are low.
- R2: Record r starts at store address r*8448 and its header at r*8448+8192. Records are tested in ascending r, and the first record whose header byte 5 equals load_num_i is the one loaded.
- R3: If none of the first num_loads_i records matches, miss_o is set and done_o pulses, with no RAM or host write. A num_loads_i of zero gives an immediate miss, and values above MAX_LOADS are treated as MAX_LOADS.
- R4: hdr_warn_o is set when the 8-bit sum of header bytes 0..7 differs from 0x55. The copy still takes place.
- R5: Header byte 3 gives the page count, clipped to 32. The source of page j is record base + j*256.
- R6: Page j's descriptor sits at header offset 16+j. Descriptor bits 1:0 give the bank and bits 4:2 give the page, and bits 7:5 are ignored. Byte i of page j is written to RAM address bank*2048 + page*256 + i. Pages are handled in ascending j, so a later page overwrites an earlier one that has the same target.
- R7: A page whose descriptor selects bank 3 produces no RAM write.
- R8: A page is valid when the 8-bit sum of its 256 bytes, its descriptor and its partner byte at header offset 64+j equals 0x55. Any invalid page sets page_warn_o, which stays set until the next accepted start. Copying continues after an invalid page.
- R9: After the last page, exactly three host writes occur in this order: address 0xFE gets header byte 0, 0xFF gets byte 1, and 0x80 gets byte 2.
- R10: The 256 RAM writes of one page take place on 256 consecutive clock cycles.
- R11: busy_o rises the cycle after an accepted start and stays high until done_o. done_o is a single-cycle pulse with busy_o low. The flags are valid at done_o and hold until the next start.
- R12: A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| load_num_i | input | 8 | Wanted load number |
| num_loads_i | input | CNT_W | Number of records present in the store |
| store_rd_o | output | 1 | Backing store read strobe |
| store_addr_o | output | STORE_AW | Backing store byte address |
| store_data_i | input | 8 | Store read data, one cycle after the strobe |
| ram_we_o | output | 1 | Banked RAM write enable |
| ram_addr_o | output | RAM_AW | Banked RAM byte address |
| ram_wdata_o | output | 8 | Banked RAM write data |
| host_we_o | output | 1 | Host RAM write enable |
| host_addr_o | output | 8 | Host RAM address |
| host_wdata_o | output | 8 | Host RAM write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| hdr_warn_o | output | 1 | Header checksum mismatch |
| page_warn_o | output | 1 | At least one page checksum mismatch |
| miss_o | output | 1 | No record carries the wanted number |

## Verification
The bench sweeps load numbers across a four-record store. Two records share the same number, so a loader that kept scanning past the first match would load the wrong one. Descriptors put pages out of order, land pages on the same target, set the ignored high bits and select the read-only bank. A loader that decoded the descriptor fields wrongly or wrote bank 3 would leave the RAM image different from the one the bench computes. Corrupted header and partner bytes check that the warnings are raised and that copying does not stop. Runs with zero records, with a number that is beyond the record limit, and with a limit above the maximum check that a miss never touches memory. A count of 40 checks the clip to 32, and a start pulse issued mid-run checks that a second start cannot redirect a running load.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam logic [7:0] SUM_OK       = 8'h55;
  localparam int         OFS_COUNT    = 3;
  localparam int         OFS_LOADNUM  = 5;
  localparam int         HDR_SUM_LEN  = 8;
  localparam int         OFS_DESC     = 16;
  localparam int         OFS_PART     = 64;
  localparam logic [7:0] HOST_A0      = 8'hFE;
  localparam logic [7:0] HOST_A1      = 8'hFF;
  localparam logic [7:0] HOST_A2      = 8'h80;
  localparam logic [1:0] RO_BANK      = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN_RD, ST_SCAN_CHK, ST_HDR_RD, ST_HDR_CAP, ST_HDR_EVAL,
    ST_DSC_RD, ST_DSC_CAP, ST_PRT_RD, ST_PRT_CAP, ST_COPY, ST_PG_EVAL,
    ST_HOST, ST_MISS, ST_FIN
  } ldr_state_e;
endpackage

// File: rtl/ldr_sum8.sv
module ldr_sum8 #(
  parameter logic [7:0] TARGET = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] init_i,
  input  logic       add_i,
  input  logic [7:0] val_i,
  output logic       ok_o
);
  logic [7:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (load_i) sum_q <= init_i;
    else if (add_i)  sum_q <= sum_q + val_i;
  end

  assign ok_o = (sum_q == TARGET);
endmodule

// File: rtl/ldr_rec_walk.sv
module ldr_rec_walk #(
  parameter int REC_BYTES = 8448,
  parameter int STORE_AW  = 17,
  parameter int CNT_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                step_i,
  input  logic [CNT_W-1:0]    limit_i,
  output logic [STORE_AW-1:0] base_o,
  output logic                last_o
);
  logic [CNT_W-1:0]    idx_q;
  logic [STORE_AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (clr_i) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
      base_q <= base_q + STORE_AW'(REC_BYTES);
    end
  end

  assign base_o = base_q;
  assign last_o = (({1'b0, idx_q} + 1'b1) == {1'b0, limit_i});
endmodule

// File: rtl/ldr_page_stream.sv
module ldr_page_stream #(
  parameter int PAGE_AW  = 8,
  parameter int STORE_AW = 17,
  parameter int RAM_AW   = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic [STORE_AW-1:0] src_i,
  input  logic [RAM_AW-1:0]   dst_i,
  input  logic                wr_ok_i,
  input  logic [7:0]          data_i,
  output logic                rd_o,
  output logic [STORE_AW-1:0] rd_addr_o,
  output logic                byte_vld_o,
  output logic                last_o,
  output logic                ram_we_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [7:0]          ram_wdata_o
);
  logic                run_q, vld_q, ok_q;
  logic [PAGE_AW-1:0]  idx_q, rx_idx_q;
  logic [STORE_AW-1:0] src_q;
  logic [RAM_AW-1:0]   dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      ok_q  <= 1'b0;
    end else if (go_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
      src_q <= src_i;
      dst_q <= dst_i;
      ok_q  <= wr_ok_i;
    end else if (run_q) begin
      idx_q <= idx_q + 1'b1;
      if (&idx_q) run_q <= 1'b0;
    end
  end

  // read data returns one cycle after the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      rx_idx_q <= '0;
    end else begin
      vld_q    <= run_q;
      rx_idx_q <= idx_q;
    end
  end

  assign rd_o        = run_q;
  assign rd_addr_o   = src_q + STORE_AW'(idx_q);
  assign byte_vld_o  = vld_q;
  assign last_o      = vld_q && (&rx_idx_q);
  assign ram_we_o    = vld_q && ok_q;
  assign ram_addr_o  = dst_q + RAM_AW'(rx_idx_q);
  assign ram_wdata_o = data_i;
endmodule

// File: rtl/multiload_loader.sv
module multiload_loader
  import ldr_pkg::*;
#(
  parameter int MAX_LOADS  = 8,
  parameter int PAGE_BYTES = 256,
  parameter int DATA_PAGES = 32,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES),
  localparam int REC_BYTES = (DATA_PAGES + 1) * PAGE_BYTES,
  localparam int STORE_AW  = $clog2(MAX_LOADS * REC_BYTES),
  localparam int CNT_W     = $clog2(MAX_LOADS + 1),
  localparam int RAM_AW    = PAGE_AW + 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          load_num_i,
  input  logic [CNT_W-1:0]    num_loads_i,
  output logic                store_rd_o,
  output logic [STORE_AW-1:0] store_addr_o,
  input  logic [7:0]          store_data_i,
  output logic                ram_we_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [7:0]          ram_wdata_o,
  output logic                host_we_o,
  output logic [7:0]          host_addr_o,
  output logic [7:0]          host_wdata_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                hdr_warn_o,
  output logic                page_warn_o,
  output logic                miss_o
);
  localparam int HDR_OFS = DATA_PAGES * PAGE_BYTES;
  localparam int PG_W    = $clog2(DATA_PAGES + 1);

  ldr_state_e         st_q;
  logic [7:0]         want_q;
  logic [CNT_W-1:0]   lim_q, lim_in;
  logic [2:0]         hidx_q;
  logic [PG_W-1:0]    pg_j_q, pg_cnt_q, cnt_in;
  logic [7:0]         hb0_q, hb1_q, hb2_q, desc_q;
  logic [1:0]         host_idx_q;
  logic               hwarn_q, pwarn_q, miss_q;

  logic [STORE_AW-1:0] rec_base, hdr_base, cp_addr, cp_src;
  logic [RAM_AW-1:0]   cp_dst;
  logic                rec_last, accept;
  logic                hsum_ok, psum_ok;
  logic                cp_rd, cp_vld, cp_last;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign lim_in   = (num_loads_i > CNT_W'(MAX_LOADS)) ? CNT_W'(MAX_LOADS) : num_loads_i;
  assign cnt_in   = (store_data_i > 8'(DATA_PAGES)) ? PG_W'(DATA_PAGES) : PG_W'(store_data_i);
  assign hdr_base = rec_base + STORE_AW'(HDR_OFS);
  assign cp_src   = rec_base + STORE_AW'({pg_j_q, {PAGE_AW{1'b0}}});
  assign cp_dst   = {desc_q[1:0], desc_q[4:2], {PAGE_AW{1'b0}}};

  ldr_rec_walk #(
    .REC_BYTES(REC_BYTES), .STORE_AW(STORE_AW), .CNT_W(CNT_W)
  ) i_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .step_i  ((st_q == ST_SCAN_CHK) && (store_data_i != want_q) && !rec_last),
    .limit_i (lim_q),
    .base_o  (rec_base),
    .last_o  (rec_last)
  );

  ldr_sum8 #(.TARGET(SUM_OK)) i_hdr_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .init_i (8'h00),
    .add_i  (st_q == ST_HDR_CAP),
    .val_i  (store_data_i),
    .ok_o   (hsum_ok)
  );

  ldr_sum8 #(.TARGET(SUM_OK)) i_page_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st_q == ST_PRT_CAP),
    .init_i (desc_q + store_data_i),
    .add_i  (cp_vld),
    .val_i  (store_data_i),
    .ok_o   (psum_ok)
  );

  ldr_page_stream #(
    .PAGE_AW(PAGE_AW), .STORE_AW(STORE_AW), .RAM_AW(RAM_AW)
  ) i_stream (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (st_q == ST_PRT_CAP),
    .src_i       (cp_src),
    .dst_i       (cp_dst),
    .wr_ok_i     (desc_q[1:0] != RO_BANK),
    .data_i      (store_data_i),
    .rd_o        (cp_rd),
    .rd_addr_o   (cp_addr),
    .byte_vld_o  (cp_vld),
    .last_o      (cp_last),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      want_q     <= '0;
      lim_q      <= '0;
      hidx_q     <= '0;
      pg_j_q     <= '0;
      pg_cnt_q   <= '0;
      hb0_q      <= '0;
      hb1_q      <= '0;
      hb2_q      <= '0;
      desc_q     <= '0;
      host_idx_q <= '0;
      hwarn_q    <= 1'b0;
      pwarn_q    <= 1'b0;
      miss_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          want_q  <= load_num_i;
          lim_q   <= lim_in;
          hwarn_q <= 1'b0;
          pwarn_q <= 1'b0;
          miss_q  <= 1'b0;
          st_q    <= (lim_in == '0) ? ST_MISS : ST_SCAN_RD;
        end
        ST_SCAN_RD:  st_q <= ST_SCAN_CHK;
        ST_SCAN_CHK: begin
          if (store_data_i == want_q) begin
            hidx_q <= '0;
            st_q   <= ST_HDR_RD;
          end else if (rec_last) st_q <= ST_MISS;
          else                   st_q <= ST_SCAN_RD;
        end
        ST_HDR_RD:  st_q <= ST_HDR_CAP;
        ST_HDR_CAP: begin
          case (hidx_q)
            3'd0:              hb0_q    <= store_data_i;
            3'd1:              hb1_q    <= store_data_i;
            3'd2:              hb2_q    <= store_data_i;
            3'(OFS_COUNT):     pg_cnt_q <= cnt_in;
            default: ;
          endcase
          hidx_q <= hidx_q + 1'b1;
          st_q   <= (hidx_q == 3'(HDR_SUM_LEN - 1)) ? ST_HDR_EVAL : ST_HDR_RD;
        end
        ST_HDR_EVAL: begin
          hwarn_q    <= !hsum_ok;
          pg_j_q     <= '0;
          host_idx_q <= '0;
          st_q       <= (pg_cnt_q == '0) ? ST_HOST : ST_DSC_RD;
        end
        ST_DSC_RD:  st_q <= ST_DSC_CAP;
        ST_DSC_CAP: begin
          desc_q <= store_data_i;
          st_q   <= ST_PRT_RD;
        end
        ST_PRT_RD:  st_q <= ST_PRT_CAP;
        ST_PRT_CAP: st_q <= ST_COPY;
        ST_COPY:    if (cp_last) st_q <= ST_PG_EVAL;
        ST_PG_EVAL: begin
          if (!psum_ok) pwarn_q <= 1'b1;
          pg_j_q <= pg_j_q + 1'b1;
          st_q   <= ((pg_j_q + 1'b1) == pg_cnt_q) ? ST_HOST : ST_DSC_RD;
        end
        ST_HOST: begin
          host_idx_q <= host_idx_q + 1'b1;
          if (host_idx_q == 2'd2) st_q <= ST_FIN;
        end
        ST_MISS: begin
          miss_q <= 1'b1;
          st_q   <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    store_rd_o   = 1'b0;
    store_addr_o = '0;
    unique case (st_q)
      ST_SCAN_RD: begin
        store_rd_o   = 1'b1;
        store_addr_o = hdr_base + STORE_AW'(OFS_LOADNUM);
      end
      ST_HDR_RD: begin
        store_rd_o   = 1'b1;
        store_addr_o = hdr_base + STORE_AW'(hidx_q);
      end
      ST_DSC_RD: begin
        store_rd_o   = 1'b1;
        store_addr_o = hdr_base + STORE_AW'(OFS_DESC) + STORE_AW'(pg_j_q);
      end
      ST_PRT_RD: begin
        store_rd_o   = 1'b1;
        store_addr_o = hdr_base + STORE_AW'(OFS_PART) + STORE_AW'(pg_j_q);
      end
      ST_COPY: begin
        store_rd_o   = cp_rd;
        store_addr_o = cp_addr;
      end
      default: ;
    endcase
  end

  always_comb begin
    host_we_o    = (st_q == ST_HOST);
    host_addr_o  = HOST_A0;
    host_wdata_o = hb0_q;
    if (host_idx_q == 2'd1) begin
      host_addr_o  = HOST_A1;
      host_wdata_o = hb1_q;
    end else if (host_idx_q == 2'd2) begin
      host_addr_o  = HOST_A2;
      host_wdata_o = hb2_q;
    end
  end

  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign done_o      = (st_q == ST_FIN);
  assign hdr_warn_o  = hwarn_q;
  assign page_warn_o = pwarn_q;
  assign miss_o      = miss_q;
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int RAM_AW = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              store_rd_o,
  input logic              ram_we_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              host_we_o,
  input logic [7:0]        host_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              hdr_warn_o,
  input logic              page_warn_o,
  input logic              miss_o
);
  AST_NO_RO_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o[RAM_AW-1 -: 2] != 2'b11)); // R7

  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!ram_we_o && !host_we_o)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ram_we_o && !host_we_o && !store_rd_o)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R11

  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R11

  AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({hdr_warn_o, page_warn_o, miss_o})); // R11

  AST_BUSY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o)); // R12

  AST_HOST_ORDER_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_o && host_addr_o == 8'hFE) |=> (host_we_o && host_addr_o == 8'hFF)); // R9

  AST_HOST_ORDER_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_o && host_addr_o == 8'hFF) |=> (host_we_o && host_addr_o == 8'h80)); // R9
endmodule

bind multiload_loader ldr_checker #(.RAM_AW(RAM_AW)) i_ldr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .store_rd_o  (store_rd_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .host_we_o   (host_we_o),
  .host_addr_o (host_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .hdr_warn_o  (hdr_warn_o),
  .page_warn_o (page_warn_o),
  .miss_o      (miss_o)
);

// File: tb/test_multiload_loader.sv
module test_multiload_loader;
  localparam int MAXL = 4;
  localparam int PB   = 256;
  localparam int NP   = 32;
  localparam int REC  = (NP + 1) * PB;
  localparam int HOFS = NP * PB;
  localparam int SAW  = $clog2(MAXL * REC);
  localparam int CW   = $clog2(MAXL + 1);
  localparam int RAW  = 13;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic           start_i = 1'b0;
  logic [7:0]     load_num_i = '0;
  logic [CW-1:0]  num_loads_i = '0;
  logic           store_rd_o, ram_we_o, host_we_o;
  logic [SAW-1:0] store_addr_o;
  logic [7:0]     store_q = '0;
  logic [RAW-1:0] ram_addr_o;
  logic [7:0]     ram_wdata_o, host_addr_o, host_wdata_o;
  logic           busy_o, done_o, hdr_warn_o, page_warn_o, miss_o;

  multiload_loader #(.MAX_LOADS(MAXL), .PAGE_BYTES(PB), .DATA_PAGES(NP)) i_multiload_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .load_num_i(load_num_i),
    .num_loads_i(num_loads_i), .store_rd_o(store_rd_o), .store_addr_o(store_addr_o),
    .store_data_i(store_q), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .host_we_o(host_we_o), .host_addr_o(host_addr_o),
    .host_wdata_o(host_wdata_o), .busy_o(busy_o), .done_o(done_o),
    .hdr_warn_o(hdr_warn_o), .page_warn_o(page_warn_o), .miss_o(miss_o)
  );

  logic [7:0] store [MAXL*REC];
  logic [7:0] ram [8192];
  logic [7:0] exp_ram [8192];
  logic [7:0] hmem [256];
  int cyc = 0, wr_cnt = 0, host_cnt = 0, first_cyc = 0, c256 = 0;
  int n_cmp = 0, n_bad = 0;
  bit timed_out = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (store_rd_o) store_q <= store[store_addr_o];
  end

  always @(negedge clk) begin
    if (ram_we_o) begin
      ram[ram_addr_o] = ram_wdata_o;
      if (wr_cnt == 0)   first_cyc = cyc;
      if (wr_cnt == 255) c256 = cyc;
      wr_cnt++;
    end
    if (host_we_o) begin
      hmem[host_addr_o] = host_wdata_o;
      host_cnt++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] dfun(int mode, int r, int j);
    if (mode == 0) return 8'(((7 - (j % 8)) << 2) | (j % 3) | ((j & 7) << 5));
    return 8'(((j % 8) << 2) | (j % 4));
  endfunction

  task automatic build_rec(int r, int lnum, int cnt, int mode, bit bad_hdr, int bad_mask);
    int b = r * REC;
    int h = b + HOFS;
    logic [7:0] s;
    int np = (cnt < NP) ? cnt : NP;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PB; i++)
        store[b + p*PB + i] = 8'(r*53 + p*7 + i*13 + (i >> 3));
    for (int k = 0; k < PB; k++) store[h + k] = 8'hFF;
    store[h+0] = 8'(r*16 + 1);
    store[h+1] = 8'(r*16 + 2);
    store[h+2] = 8'(r*16 + 3);
    store[h+3] = 8'(cnt);
    store[h+4] = 8'h00;
    store[h+5] = 8'(lnum);
    store[h+6] = 8'h00;
    s = 8'h00;
    for (int k = 0; k < 7; k++) s = s + store[h+k];
    store[h+7] = 8'h55 - s + (bad_hdr ? 8'h01 : 8'h00);
    for (int j = 0; j < np; j++) begin
      s = dfun(mode, r, j);
      store[h + 16 + j] = s;
      for (int i = 0; i < PB; i++) s = s + store[b + j*PB + i];
      store[h + 64 + j] = (8'h55 - s) ^ (bad_mask[j] ? 8'h01 : 8'h00);
    end
  endtask

  // r < 0: no match expected
  task automatic run(int lnum, int nl, int r, bit inject);
    int h = r * REC + HOFS;
    int np, e_wr = 0, nd = 0;
    bit e_hw = 0, e_pw = 0;
    logic [7:0] s;
    logic [2:0] f0;
    for (int a = 0; a < 8192; a++) exp_ram[a] = ram[a];
    for (int a = 0; a < 256; a++) hmem[a] = 8'h00;
    if (r >= 0) begin
      s = 8'h00;
      for (int k = 0; k < 8; k++) s = s + store[h+k];
      e_hw = (s != 8'h55);
      np = (store[h+3] > NP) ? NP : int'(store[h+3]);
      for (int j = 0; j < np; j++) begin
        logic [7:0] d = store[h + 16 + j];
        s = d + store[h + 64 + j];
        for (int i = 0; i < PB; i++) begin
          s = s + store[r*REC + j*PB + i];
          if (d[1:0] != 2'b11) exp_ram[d[1:0]*2048 + d[4:2]*256 + i] = store[r*REC + j*PB + i];
        end
        if (d[1:0] != 2'b11) e_wr += PB;
        if (s != 8'h55) e_pw = 1;
      end
    end
    wr_cnt = 0; host_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; load_num_i = 8'(lnum); num_loads_i = CW'(nl);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
    if (inject) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1; load_num_i = 8'd10;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && cyc < WD) @(negedge clk);
    if (!done_o) begin
      timed_out = 1;
      chk(0, "R11", "watchdog expired", cyc, WD);
      return;
    end
    chk(busy_o == 1'b0, "R11", "busy low at done", busy_o, 0);
    chk(miss_o == (r < 0), "R3", "miss flag", miss_o, r < 0);
    chk(hdr_warn_o == e_hw, "R4", "header warning", hdr_warn_o, e_hw);
    chk(page_warn_o == e_pw, "R8", "page warning", page_warn_o, e_pw);
    f0 = {hdr_warn_o, page_warn_o, miss_o};
    @(negedge clk);
    chk(done_o == 1'b0, "R11", "done single cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk({hdr_warn_o, page_warn_o, miss_o} == f0, "R11", "flags held", int'({hdr_warn_o, page_warn_o, miss_o}), int'(f0));
    for (int a = 0; a < 8192; a++)
      if (ram[a] !== exp_ram[a]) begin
        if (nd == 0) $display("  first RAM difference at %0d", a);
        nd++;
      end
    chk(nd == 0, (r < 0) ? "R3" : "R6", "RAM bytes differing", nd, 0);
    chk(wr_cnt == e_wr, (r < 0) ? "R3" : "R7", "RAM write count", wr_cnt, e_wr);
    if (r < 0) chk(host_cnt == 0, "R3", "host writes on miss", host_cnt, 0);
    else begin
      chk(host_cnt == 3, "R9", "host write count", host_cnt, 3);
      chk(hmem[8'hFE] == store[h+0], "R9", "host 0xFE", hmem[8'hFE], store[h+0]);
      chk(hmem[8'hFF] == store[h+1], "R9", "host 0xFF", hmem[8'hFF], store[h+1]);
      chk(hmem[8'h80] == store[h+2], "R9", "host 0x80", hmem[8'h80], store[h+2]);
    end
    if (e_wr >= PB) chk(c256 - first_cyc == PB - 1, "R10", "page write span", c256 - first_cyc, PB - 1);
  endtask

  initial begin
    for (int a = 0; a < 8192; a++) ram[a] = 8'h00;
    build_rec(0, 10, 4, 0, 0, 0);
    build_rec(1, 11, 8, 1, 0, 0);
    build_rec(2, 12, 6, 0, 0, 0);
    build_rec(3, 11, 5, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, hdr_warn_o, page_warn_o, miss_o, ram_we_o, host_we_o, store_rd_o} == 8'h00,
        "R1", "outputs in reset", 0, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, hdr_warn_o, page_warn_o, miss_o, ram_we_o, host_we_o, store_rd_o} == 8'h00,
        "R1", "outputs after reset", 0, 0);

    run(12, 4, 2, 0);                                // R6 out-of-order placement
    if (!timed_out) run(11, 4, 1, 0);                // R2 first of duplicates, R7 bank 3
    if (!timed_out) chk(hmem[8'hFE] == 8'd17, "R2", "first matching record chosen", hmem[8'hFE], 17);
    if (!timed_out) begin build_rec(0, 10, 4, 0, 1, 0); run(10, 4, 0, 0); end          // R4
    if (!timed_out) begin build_rec(3, 13, 5, 0, 0, 32'b01010); run(13, 4, 3, 0); end  // R8
    if (!timed_out) run(99, 4, -1, 0);               // R3
    if (!timed_out) run(13, 3, -1, 0);               // R3 record beyond limit
    if (!timed_out) run(12, 0, -1, 0);               // R3 zero records
    if (!timed_out) run(13, 7, 3, 0);                // R3 limit clipped
    if (!timed_out) run(77, 7, -1, 0);               // R3
    if (!timed_out) begin build_rec(1, 11, 40, 0, 0, 0); run(11, 4, 1, 0);
      chk(wr_cnt == NP * PB, "R5", "page count clipped", wr_cnt, NP * PB); end
    if (!timed_out) begin
      for (int a = 0; a < 8192; a++) ram[a] = 8'h00;
      run(12, 4, 2, 1);                              // R12 second start ignored
      chk(hmem[8'hFE] == 8'd33, "R12", "load kept after mid-run start", hmem[8'hFE], 33);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule